// File: doc/BRIEF.md
# Masked interrupt register bank

This block is a small bank of word-addressed 32-bit registers on a plain synchronous register bus: an address, a write strobe with write data, and a read strobe with registered read data. Four of the addresses form an interrupt group. Those four are a raw pending register, a write-only clear port, a mask register, and a read-only masked view. Every other address inside the bank is ordinary read/write storage.

Internal logic reports events through a vector of single-cycle pulses, and each pulse latches its bit into the raw pending register. Software can also raise pending bits by writing the raw register. It retires them by writing ones to the clear port, and chooses which bits reach the single level-sensitive interrupt line by programming the mask. The line is high whenever any pending bit is also enabled. Where the four group registers sit is set by parameters, and so are the bank size and the event width.

Top module: `irq_regbank`

## Requirements
- R1: While the synchronous active-low reset is applied, every register is cleared to zero. This covers raw pending, mask, all storage words and the read data output. The interrupt line is low after reset.
- R2: A write to the raw address (default 8) ORs the write data into the raw pending register, and bits that are already set stay set. Reading the raw address returns the stored raw value.
- R3: A write to the clear address (default 9) clears every raw bit that is 1 in the write data and leaves the other bits alone. The clear address stores nothing and always reads as zero.
- R4: A bit of the event input that is high at a clock edge sets the raw bit with the same index at that edge. The event bit is zero-extended to the data width. If an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R5: A write to the mask address (default 10) stores the word, and reading it returns that word. Reading the status address (default 11) returns raw AND mask.
- R6: Writes to the status address change no register: raw, mask and the status view all keep their values.
- R7: The interrupt line is high exactly when raw AND mask is non-zero. It changes in the cycle after the write or event that caused the change.
- R8: Any in-range address outside the interrupt group stores the written word and returns it on read.
- R9: Writes to addresses at or above the register count (default 16) are dropped, and no in-range register is altered by them. Reads of such addresses return zero.
- R10: Read data is registered. It shows the value of the addressed register from before the clock edge at which the read strobe was sampled, including when a write to the same address happens in that cycle. It holds its value while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W (6) | Word address for both read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W (32) | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W (32) | Registered read data |
| evt | input | EVT_W (32) | Event pulses, one per raw bit |
| irq | output | 1 | Level interrupt, raw AND mask non-zero |

## Verification
The bench pits an event pulse against a clear of the same bit in one cycle. A design that lets the clear win would lose that event silently. It writes the status address with all ones and then reads back raw, mask and status. A block that decoded status as a storage or mask alias would show the written pattern there. It writes to out-of-range addresses whose low bits alias an in-range word. Truncating the address instead of range-checking it would corrupt that word. It also reads and writes one address in the same cycle and changes the mask while pending bits are set. A read path that bypassed the write, or an interrupt line computed a cycle late or from stale state, would return the wrong word or move irq at the wrong edge.

// File: rtl/irq_regbank_pkg.sv
// Shared types for the masked interrupt register bank.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable subset.
package irq_regbank_pkg;

    // Which part of the bank an address selects.
    typedef enum logic [2:0] {
        SEL_RAW   = 3'd0,
        SEL_CLR   = 3'd1,
        SEL_MSK   = 3'd2,
        SEL_STS   = 3'd3,
        SEL_PLAIN = 3'd4,
        SEL_NONE  = 3'd5
    } bank_sel_e;

endpackage

// File: rtl/irq_regbank_decode.sv
// Address decoder: classifies a word address into one of the interrupt
// group registers, plain storage, or out-of-range, and gives the word index.
// Assumes: all four group addresses are distinct and below NUM_REGS.
module irq_regbank_decode
    import irq_regbank_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int NUM_REGS = 16,
    parameter int A_RAW    = 8,
    parameter int A_CLR    = 9,
    parameter int A_MSK    = 10,
    parameter int A_STS    = 11,
    parameter int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output bank_sel_e         sel,
    output logic [IDX_W-1:0]  idx
);

    localparam logic [ADDR_W:0]   LIMIT    = (ADDR_W+1)'(NUM_REGS);
    localparam logic [ADDR_W-1:0] ADDR_RAW = ADDR_W'(A_RAW);
    localparam logic [ADDR_W-1:0] ADDR_CLR = ADDR_W'(A_CLR);
    localparam logic [ADDR_W-1:0] ADDR_MSK = ADDR_W'(A_MSK);
    localparam logic [ADDR_W-1:0] ADDR_STS = ADDR_W'(A_STS);

    logic in_range;

    // Range check against the configured register count.
    always_comb in_range = ({1'b0, addr} < LIMIT);

    // Low address bits index the storage array.
    always_comb idx = addr[IDX_W-1:0];

    // Classify the address; group addresses win over plain storage.
    always_comb begin
        if (!in_range)              sel = SEL_NONE;
        else if (addr == ADDR_RAW)  sel = SEL_RAW;
        else if (addr == ADDR_CLR)  sel = SEL_CLR;
        else if (addr == ADDR_MSK)  sel = SEL_MSK;
        else if (addr == ADDR_STS)  sel = SEL_STS;
        else                        sel = SEL_PLAIN;
    end

endmodule

// File: rtl/irq_regbank_irqgrp.sv
// Interrupt group: raw pending register with set/clear semantics, mask
// register, and the level interrupt derived from both registered values.
// Assumes: set, clear and mask write strobes are mutually exclusive (one bus
// write per cycle); events may coincide with any of them and win over clear.
module irq_regbank_irqgrp #(
    parameter int DATA_W = 32,
    parameter int EVT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_wr,
    input  logic              clr_wr,
    input  logic              msk_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [EVT_W-1:0]  evt,
    output logic [DATA_W-1:0] raw_q,
    output logic [DATA_W-1:0] mask_q,
    output logic              irq
);

    logic [DATA_W-1:0] evt_ext;
    logic [DATA_W-1:0] set_bits;
    logic [DATA_W-1:0] clr_bits;
    logic [DATA_W-1:0] raw_d;

    // Widen the event vector to the register width.
    always_comb evt_ext = DATA_W'(evt);

    // Gather the bits to set and to clear this cycle.
    always_comb begin
        set_bits = evt_ext | (set_wr ? wdata : '0);
        clr_bits = clr_wr ? wdata : '0;
    end

    // Next raw value: clear first, then set so that a set wins.
    always_comb raw_d = (raw_q & ~clr_bits) | set_bits;

    // Raw pending register.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= raw_d;
    end

    // Mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)      mask_q <= '0;
        else if (msk_wr) mask_q <= wdata;
    end

    // Level interrupt from the two registered values.
    always_comb irq = |(raw_q & mask_q);

endmodule

// File: rtl/irq_regbank_store.sv
// Plain storage words of the bank, one register per word address.
// Assumes: the caller only raises we for plain-storage addresses and
// ignores rdata for any other address.
module irq_regbank_store #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 16,
    parameter int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] word_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        // One storage word, written when its index is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)                          word_q[g] <= '0;
            else if (we && widx == IDX_W'(g))    word_q[g] <= wdata;
        end
    end

    // Read mux; out-of-array indices return zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (ridx == IDX_W'(i)) rdata = word_q[i];
    end

endmodule

// File: rtl/irq_regbank.sv
// Top of the masked interrupt register bank: decodes the register bus,
// steers writes to the interrupt group or storage, and registers read data.
// Assumes: one bus address per cycle shared by read and write; a read in the
// same cycle as a write returns the pre-write value.
module irq_regbank
    import irq_regbank_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 6,
    parameter int NUM_REGS = 16,
    parameter int EVT_W    = 32,
    parameter int A_RAW    = 8,
    parameter int A_CLR    = 9,
    parameter int A_MSK    = 10,
    parameter int A_STS    = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic [EVT_W-1:0]  evt,
    output logic              irq
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    bank_sel_e         sel;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] raw_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] store_rdata;
    logic [DATA_W-1:0] rd_mux;
    logic              set_wr, clr_wr, msk_wr, sto_wr;

    irq_regbank_decode #(
        .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
        .A_RAW(A_RAW), .A_CLR(A_CLR), .A_MSK(A_MSK), .A_STS(A_STS),
        .IDX_W(IDX_W)
    ) u_decode (
        .addr (addr),
        .sel  (sel),
        .idx  (idx)
    );

    // Write strobes per target; status and out-of-range get none.
    always_comb begin
        set_wr = wr_en && (sel == SEL_RAW);
        clr_wr = wr_en && (sel == SEL_CLR);
        msk_wr = wr_en && (sel == SEL_MSK);
        sto_wr = wr_en && (sel == SEL_PLAIN);
    end

    irq_regbank_irqgrp #(
        .DATA_W(DATA_W), .EVT_W(EVT_W)
    ) u_irqgrp (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_wr (set_wr),
        .clr_wr (clr_wr),
        .msk_wr (msk_wr),
        .wdata  (wr_data),
        .evt    (evt),
        .raw_q  (raw_q),
        .mask_q (mask_q),
        .irq    (irq)
    );

    irq_regbank_store #(
        .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (sto_wr),
        .widx  (idx),
        .wdata (wr_data),
        .ridx  (idx),
        .rdata (store_rdata)
    );

    // Select the read value from the current (pre-edge) register state.
    always_comb begin
        unique case (sel)
            SEL_RAW:   rd_mux = raw_q;
            SEL_CLR:   rd_mux = '0;
            SEL_MSK:   rd_mux = mask_q;
            SEL_STS:   rd_mux = raw_q & mask_q;
            SEL_PLAIN: rd_mux = store_rdata;
            default:   rd_mux = '0;
        endcase
    end

    // Registered read data, held while no read is requested.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

endmodule

// File: rtl/irq_regbank_checker.sv
// Assertion checker for irq_regbank, attached with bind below.
// Assumes: raw_q and mask_q are the top's internal registered raw and mask.
module irq_regbank_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    parameter int EVT_W  = 32,
    parameter int A_RAW  = 8,
    parameter int A_CLR  = 9,
    parameter int A_MSK  = 10,
    parameter int A_STS  = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic [EVT_W-1:0]  evt,
    input logic              irq,
    input logic [DATA_W-1:0] raw_q,
    input logic [DATA_W-1:0] mask_q
);

    localparam logic [ADDR_W-1:0] CA_RAW = ADDR_W'(A_RAW);
    localparam logic [ADDR_W-1:0] CA_CLR = ADDR_W'(A_CLR);
    localparam logic [ADDR_W-1:0] CA_STS = ADDR_W'(A_STS);

    logic [DATA_W-1:0] evt_w;
    always_comb evt_w = DATA_W'(evt);

    assert_raw_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CA_RAW) |=>
            ((raw_q & $past(wr_data)) == $past(wr_data)) &&
            ((raw_q & $past(raw_q)) == $past(raw_q)));

    assert_clear_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CA_CLR && evt == '0) |=>
            ((raw_q & $past(wr_data)) == '0));

    assert_event_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((raw_q & $past(evt_w)) == $past(evt_w)));

    assert_status_no_effect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CA_STS) |=> $stable(mask_q));

    assert_irq_needs_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q != '0) && (raw_q != '0));

    assert_irq_rise_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(wr_en) || ($past(evt) != '0)));

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

bind irq_regbank irq_regbank_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .EVT_W(EVT_W),
    .A_RAW(A_RAW), .A_CLR(A_CLR), .A_MSK(A_MSK), .A_STS(A_STS)
) u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .evt     (evt),
    .irq     (irq),
    .raw_q   (raw_q),
    .mask_q  (mask_q)
);

// File: tb/irq_regbank_bench.sv
// Self-checking bench for irq_regbank: directed corner cases plus seeded
// random traffic, compared against a behavioural model built from the brief.
module irq_regbank_bench;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 6;
    localparam int NUM_REGS = 16;
    localparam int EVT_W    = 32;
    localparam int A_RAW    = 8;
    localparam int A_CLR    = 9;
    localparam int A_MSK    = 10;
    localparam int A_STS    = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_en = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic [EVT_W-1:0]  evt = '0;
    logic              irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Behavioural model state
    logic [DATA_W-1:0] m_raw, m_mask, m_rd;
    logic [DATA_W-1:0] m_store [NUM_REGS];

    always #5 clk = ~clk;

    irq_regbank #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .EVT_W(EVT_W),
        .A_RAW(A_RAW), .A_CLR(A_CLR), .A_MSK(A_MSK), .A_STS(A_STS)
    ) u_irq_regbank (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .evt(evt), .irq(irq)
    );

    function automatic logic [DATA_W-1:0] model_read(input int a);
        if (a >= NUM_REGS) return '0;
        if (a == A_RAW)    return m_raw;
        if (a == A_CLR)    return '0;
        if (a == A_MSK)    return m_mask;
        if (a == A_STS)    return m_raw & m_mask;
        return m_store[a];
    endfunction

    task automatic model_reset();
        m_raw = '0; m_mask = '0; m_rd = '0;
        for (int i = 0; i < NUM_REGS; i++) m_store[i] = '0;
    endtask

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One bus cycle; called at a negedge, returns at the next negedge after
    // comparing read data and interrupt against the model.
    task automatic step(input string req, input bit w, input bit r,
                        input int a, input logic [DATA_W-1:0] d,
                        input logic [EVT_W-1:0] e);
        logic [DATA_W-1:0] setv, clrv;
        addr = ADDR_W'(a); wr_en = w; rd_en = r; wr_data = d; evt = e;
        if (r) m_rd = model_read(a);
        setv = DATA_W'(e); clrv = '0;
        if (w && a < NUM_REGS) begin
            if (a == A_RAW)      setv = setv | d;
            else if (a == A_CLR) clrv = d;
            else if (a == A_MSK) m_mask = d;
            else if (a != A_STS) m_store[a] = d;
        end
        m_raw = (m_raw & ~clrv) | setv;
        @(posedge clk);
        #2;
        wr_en = 1'b0; rd_en = 1'b0; evt = '0;
        check({req, " rd_data"}, rd_data, m_rd);
        check({req, " irq"}, DATA_W'(irq), DATA_W'(|(m_raw & m_mask)));
        @(negedge clk);
    endtask

    task automatic rd(input string req, input int a, input logic [DATA_W-1:0] exp);
        step(req, 1'b0, 1'b1, a, '0, '0);
        check({req, " directed"}, rd_data, exp);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int a;
        logic [DATA_W-1:0] d;
        logic [EVT_W-1:0] e;
        void'($urandom(32'h1a2b3c4d));
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset rd_data", rd_data, '0);
        check("R1 reset irq", DATA_W'(irq), '0);
        rst_n = 1'b1;
        @(negedge clk);
        rd("R1 raw after reset", A_RAW, '0);
        rd("R1 mask after reset", A_MSK, '0);

        // R2: raw write ORs
        step("R2 set", 1'b1, 1'b0, A_RAW, 32'h0000_0005, '0);
        step("R2 set", 1'b1, 1'b0, A_RAW, 32'h0000_0030, '0);
        rd("R2 raw or", A_RAW, 32'h0000_0035);

        // R3: clear bits, clear address reads zero
        step("R3 clr", 1'b1, 1'b0, A_CLR, 32'h0000_0004, '0);
        rd("R3 raw cleared", A_RAW, 32'h0000_0031);
        rd("R3 clear reads zero", A_CLR, '0);

        // R5 / R7: mask and interrupt timing
        check("R7 irq masked off", DATA_W'(irq), '0);
        step("R7 mask on", 1'b1, 1'b0, A_MSK, 32'h0000_0001, '0);
        check("R7 irq after mask", DATA_W'(irq), 32'd1);
        rd("R5 mask readback", A_MSK, 32'h0000_0001);
        rd("R5 status masked", A_STS, 32'h0000_0001);
        step("R7 clear pending", 1'b1, 1'b0, A_CLR, 32'h0000_0001, '0);
        check("R7 irq drops", DATA_W'(irq), '0);

        // R6: status write ignored
        step("R6 sts write", 1'b1, 1'b0, A_STS, 32'hFFFF_FFFF, '0);
        rd("R6 raw kept", A_RAW, 32'h0000_0030);
        rd("R6 mask kept", A_MSK, 32'h0000_0001);
        rd("R6 status kept", A_STS, 32'h0000_0000);

        // R4: event vs clear on the same bit, event wins
        step("R4 set bit0", 1'b1, 1'b0, A_RAW, 32'h0000_0001, '0);
        step("R4 evt vs clr", 1'b1, 1'b0, A_CLR, 32'h0000_0101, 32'h0000_0100);
        rd("R4 event wins", A_RAW, 32'h0000_0130);
        step("R4 evt only", 1'b0, 1'b0, 0, '0, 32'h8000_0000);
        rd("R4 evt bit31", A_RAW, 32'h8000_0130);

        // R8: plain storage
        step("R8 store", 1'b1, 1'b0, 2, 32'hDEAD_BEEF, '0);
        rd("R8 readback", 2, 32'hDEAD_BEEF);

        // R9: out of range write dropped (aliases word 4), read zero
        step("R9 store4", 1'b1, 1'b0, 4, 32'h1234_5678, '0);
        step("R9 oor write", 1'b1, 1'b0, 20, 32'hAAAA_5555, '0);
        step("R9 oor raw alias", 1'b1, 1'b0, 24, 32'h0000_0002, '0);
        rd("R9 oor reads zero", 20, '0);
        rd("R9 alias untouched", 4, 32'h1234_5678);
        rd("R9 raw untouched", A_RAW, 32'h8000_0130);

        // R10: read during write returns old, idle holds
        step("R10 rw same", 1'b1, 1'b1, 2, 32'h0BAD_F00D, '0);
        check("R10 old value", rd_data, 32'hDEAD_BEEF);
        step("R10 idle", 1'b0, 1'b0, 2, '0, '0);
        check("R10 hold", rd_data, 32'hDEAD_BEEF);
        rd("R10 new value", 2, 32'h0BAD_F00D);

        // Random traffic across all requirements
        for (int n = 0; n < 4000; n++) begin
            a = int'($urandom % 24);
            if ($urandom % 3 == 0) a = A_RAW + int'($urandom % 4);
            d = $urandom;
            if ($urandom % 2 == 0) d = d & 32'h0000_00FF;
            e = '0;
            if ($urandom % 5 == 0) e = EVT_W'(1) << ($urandom % EVT_W);
            step("R2/R3/R4/R5/R7/R8/R9/R10 random", ($urandom % 2) == 1,
                 ($urandom % 2) == 1, a, d, e);
        end

        // R1: reset mid-run clears everything
        step("R1 pre", 1'b1, 1'b0, A_MSK, 32'hFFFF_FFFF, '0);
        step("R1 pre", 1'b1, 1'b0, A_RAW, 32'h0000_0010, '0);
        rd("R1 pre raw", A_RAW, m_raw);
        rst_n = 1'b0;
        @(posedge clk); #2;
        model_reset();
        check("R1 mid reset rd_data", rd_data, '0);
        check("R1 mid reset irq", DATA_W'(irq), '0);
        @(negedge clk);
        rst_n = 1'b1;
        rd("R1 raw zero", A_RAW, '0);
        rd("R1 mask zero", A_MSK, '0);
        rd("R1 store zero", 2, '0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule